// File: doc/BRIEF.md
# Extended-Format Effective Address Generator

This block turns one memory-reference instruction of the extended machine (the three-byte short form or the four-byte long form) into the address its operand lives at. It takes a four-byte instruction window plus the current base register, index register and the address of the byte that follows the instruction. From the six mode bits it works out the instruction length and the addressing mode, and then forms a 20-bit target address. The displacement is added to the base register or to the program counter, or it is used as is. Otherwise the long address field or the legacy 15-bit address is used. The index register is added when the x bit asks for it.

Immediate operands are flagged rather than fetched. An indirect reference costs one extra memory word read through a request/acknowledge port, and the word returned is the effective address. Contradictory mode bits end the operation with an error flag in place of an address. Every operation finishes with a one-cycle done pulse. The results stay on the outputs until the next operation finishes. A start that arrives while an indirect read is pending is ignored.

Top module: `xea_unit`

## Requirements
- R1: The window holds the opcode in bits 31:26 and the flags n, i, x, b, p, e in bits 25 to 20. When e=1 and n or i is set, the reported length is 4; every other accepted instruction reports 3.
- R2: When b=1, p=0 and e=0 (n or i set), the target is the low 20 bits of the base register plus the 12-bit displacement in bits 19:8, taken as unsigned. The sum wraps modulo 2^20.
- R3: When b=0, p=1 and e=0 (n or i set), the target is the PC input plus the displacement taken as a signed 12-bit value. The sum wraps modulo 2^20.
- R4: When b=0, p=0 and e=0, the target is the zero-extended displacement. When e=1 with b=p=0, it is the 20-bit address in bits 19:0.
- R5: When x=1, the low 20 bits of the index register are added to the target, modulo 2^20.
- R6: When n=0 and i=1, done arrives with the immediate flag set and the effective address equal to the target. No memory request is made.
- R7: When n=0 and i=0, the target is bits 22:8 (b, p, e and the displacement) as a 15-bit address, plus the index when x=1. In this form b=p=1 is legal, and the length is 3.
- R8: When n=1 and i=0, the unit raises the memory request with the target on the address port. It holds both until acknowledge. It then takes the low 20 bits of the read data as the effective address and pulses done one cycle after the acknowledge cycle.
- R9: Certain flag combinations are illegal: b=p=1 with n or i set, e=1 with b or p set, e=1 with n=i=0, and x=1 with immediate or indirect. For these the unit pulses done with the error flag set, the effective address at 0, the immediate flag clear and no memory request.
- R10: For every mode except indirect, done is high for exactly the one cycle after the cycle in which start is sampled.
- R11: While an indirect read is pending, the unit is busy and ignores start. The pending result and the count of done pulses are unaffected.
- R12: After reset, done, error, busy and the memory request are low, and the effective address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation on the current window (sampled when idle) |
| instr | input | 32 | Instruction window, first byte in bits 31:24 |
| base_val | input | 24 | Base register contents |
| idx_val | input | 24 | Index register contents |
| pc_val | input | 20 | Address of the byte after the instruction |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 20 | Address of the indirect word |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 24 | Word returned by memory |
| busy | output | 1 | Indirect read in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation had an illegal mode combination |
| imm | output | 1 | Last effective address is an immediate operand |
| ilen | output | 3 | Length in bytes of the last instruction |
| ea | output | 20 | Last effective address |

## Verification
The bench goes after the arithmetic edges: a base sum and an indexed long address that both cross 2^20, and a PC-relative displacement of -2048 that must borrow through the top bit. It checks that a base-relative displacement of 0xFFF stays positive; a design that sign-extends the wrong mode lands 4 KiB away. The legacy form is driven with b=p=1, which must not be mistaken for an error, and each illegal combination is tried for a stray memory request or a leaked address. Indirect reads are held off for several cycles with a stray start in between, so a design that drops the request early, reads the address at the wrong time or accepts the second start returns the wrong address or an extra done.

// File: rtl/xea_pkg.sv
`timescale 1ns/1ps
package xea_pkg;

   typedef struct packed {
      logic n;
      logic i;
      logic x;
      logic b;
      logic p;
      logic e;
   } xea_flags_t;

   typedef enum logic [2:0] {
      AM_LEGACY = 3'd0,
      AM_DIRECT = 3'd1,
      AM_BASE   = 3'd2,
      AM_PCREL  = 3'd3,
      AM_LONG   = 3'd4
   } xea_amode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_FIN  = 2'd2
   } xea_state_e;

endpackage

// File: rtl/xea_decode.sv
`timescale 1ns/1ps
module xea_decode
   import xea_pkg::*;
#(
   parameter int unsigned LONG_W = 20,
   parameter int unsigned LEN_W  = 3
) (
   input  logic [5:0]       flag_bits,
   output xea_flags_t       flags,
   output xea_amode_e       amode,
   output logic             is_imm,
   output logic             is_ind,
   output logic             bad,
   output logic [LEN_W-1:0] len
);
   localparam int unsigned SHORT_BYTES = (LONG_W + 4) / 8;
   localparam int unsigned LONG_BYTES  = (LONG_W + 12) / 8;

   logic sic_form;

   always_comb begin
      flags    = flag_bits;
      sic_form = ~flags.n & ~flags.i;
      is_imm   = ~flags.n &  flags.i;
      is_ind   =  flags.n & ~flags.i;
      if (sic_form)
         amode = AM_LEGACY;
      else if (flags.e)
         amode = AM_LONG;
      else if (flags.b)
         amode = AM_BASE;
      else if (flags.p)
         amode = AM_PCREL;
      else
         amode = AM_DIRECT;
      if (sic_form)
         bad = flags.e;
      else
         bad = (flags.b & flags.p) | (flags.e & (flags.b | flags.p)) |
               (flags.x & (is_imm | is_ind));
      len = (!sic_form && flags.e) ? LEN_W'(LONG_BYTES) : LEN_W'(SHORT_BYTES);
   end

endmodule

// File: rtl/xea_agen.sv
`timescale 1ns/1ps
module xea_agen
   import xea_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned WORD_W = 24,
   parameter int unsigned DISP_W = 12,
   parameter int unsigned LONG_W = 20
) (
   input  xea_amode_e        amode,
   input  logic              use_idx,
   input  logic [LONG_W+2:0] field,
   input  logic [WORD_W-1:0] base_val,
   input  logic [WORD_W-1:0] idx_val,
   input  logic [ADDR_W-1:0] pc_val,
   output logic [ADDR_W-1:0] ta
);
   localparam int unsigned LEG_W = DISP_W + 3;

   logic [DISP_W-1:0] disp;
   logic [LEG_W-1:0]  leg_addr;
   logic [ADDR_W-1:0] long_addr;
   logic [ADDR_W-1:0] disp_u;
   logic [ADDR_W-1:0] disp_s;
   logic [ADDR_W-1:0] raw;

   assign disp     = field[LONG_W-1 -: DISP_W];
   assign leg_addr = field[LONG_W+2 -: LEG_W];
   assign disp_u   = {{(ADDR_W-DISP_W){1'b0}}, disp};
   assign disp_s   = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};

   generate
      if (LONG_W < ADDR_W) begin : g_long_ext
         assign long_addr = {{(ADDR_W-LONG_W){1'b0}}, field[LONG_W-1:0]};
      end else begin : g_long_full
         assign long_addr = field[LONG_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (amode)
         AM_BASE:   raw = base_val[ADDR_W-1:0] + disp_u;
         AM_PCREL:  raw = pc_val + disp_s;
         AM_LONG:   raw = long_addr;
         AM_LEGACY: raw = {{(ADDR_W-LEG_W){1'b0}}, leg_addr};
         default:   raw = disp_u;
      endcase
      ta = use_idx ? raw + idx_val[ADDR_W-1:0] : raw;
   end

endmodule

// File: rtl/xea_unit.sv
`timescale 1ns/1ps
module xea_unit
   import xea_pkg::*;
#(
   parameter int unsigned ADDR_W  = 20,
   parameter int unsigned WORD_W  = 24,
   parameter int unsigned DISP_W  = 12,
   parameter int unsigned LONG_W  = 20,
   parameter int unsigned LEN_W   = 3,
   parameter int unsigned INSTR_W = LONG_W + 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [INSTR_W-1:0] instr,
   input  logic [WORD_W-1:0]  base_val,
   input  logic [WORD_W-1:0]  idx_val,
   input  logic [ADDR_W-1:0]  pc_val,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ack,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic               busy,
   output logic               done,
   output logic               err,
   output logic               imm,
   output logic [LEN_W-1:0]   ilen,
   output logic [ADDR_W-1:0]  ea
);
   generate
      if (WORD_W < ADDR_W || LONG_W > ADDR_W || DISP_W + 3 > LONG_W ||
          DISP_W + 3 > ADDR_W || INSTR_W != LONG_W + 12) begin : g_bad_cfg
         $error("xea_unit: inconsistent width parameters");
      end
   endgenerate

   xea_flags_t        flags;
   xea_amode_e        amode;
   logic              d_imm, d_ind, d_bad;
   logic [LEN_W-1:0]  d_len;
   logic [ADDR_W-1:0] ta;
   xea_state_e        state;
   logic              unused_bits;

   assign unused_bits = ^{instr[INSTR_W-1 -: 6], flags.n, flags.i, flags.b, flags.p, flags.e};

   xea_decode #(.LONG_W(LONG_W), .LEN_W(LEN_W)) u_dec (
      .flag_bits (instr[LONG_W+5:LONG_W]),
      .flags     (flags),
      .amode     (amode),
      .is_imm    (d_imm),
      .is_ind    (d_ind),
      .bad       (d_bad),
      .len       (d_len)
   );

   xea_agen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .DISP_W(DISP_W), .LONG_W(LONG_W)) u_agen (
      .amode    (amode),
      .use_idx  (flags.x),
      .field    (instr[LONG_W+2:0]),
      .base_val (base_val),
      .idx_val  (idx_val),
      .pc_val   (pc_val),
      .ta       (ta)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         mem_req  <= 1'b0;
         mem_addr <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         imm      <= 1'b0;
         ilen     <= '0;
         ea       <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  ilen <= d_len;
                  if (d_bad) begin
                     err  <= 1'b1;
                     imm  <= 1'b0;
                     ea   <= '0;
                     done <= 1'b1;
                  end else if (d_ind) begin
                     err      <= 1'b0;
                     imm      <= 1'b0;
                     mem_req  <= 1'b1;
                     mem_addr <= ta;
                     state    <= ST_WAIT;
                  end else begin
                     err  <= 1'b0;
                     imm  <= d_imm;
                     ea   <= ta;
                     done <= 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (mem_ack) begin
                  ea      <= mem_rdata[ADDR_W-1:0];
                  mem_req <= 1'b0;
                  state   <= ST_FIN;
               end
            end
            default: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
   // R8
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !done ##1 done);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   bad_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && d_bad |=> done && err && !mem_req && ea == '0);
   // R10
   quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !d_ind |=> done && !busy);
   // R11
   busy_nodone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !done);

endmodule

// File: tb/xea_unit_tb.sv
`timescale 1ns/1ps
module xea_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [23:0] base_val = '0;
   logic [23:0] idx_val = '0;
   logic [19:0] pc_val = '0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [23:0] mem_rdata = '0;
   logic        busy, done, err, imm;
   logic [2:0]  ilen;
   logic [19:0] ea;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   xea_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
      .base_val(base_val), .idx_val(idx_val), .pc_val(pc_val),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .err(err), .imm(imm), .ilen(ilen), .ea(ea)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // flags order: n i x b p e
   function automatic logic [31:0] mk3(input logic [5:0] fl, input logic [11:0] disp);
      return {6'h2A, fl, disp, 8'h5A};
   endfunction

   function automatic logic [31:0] mk4(input logic [5:0] fl, input logic [19:0] adr);
      return {6'h2A, fl, adr};
   endfunction

   task automatic run_one(input string req, input logic [31:0] ins, input logic [23:0] b,
                          input logic [23:0] x, input logic [19:0] pc, input logic [19:0] exp_ea,
                          input logic exp_imm, input logic exp_err, input logic [2:0] exp_len);
      instr = ins; base_val = b; idx_val = x; pc_val = pc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " done"}, done, 1);
      chk({req, " ea"}, ea, exp_ea);
      chk({req, " imm"}, imm, exp_imm);
      chk({req, " err"}, err, exp_err);
      if (exp_len != 0) chk({req, " len R1"}, ilen, exp_len);
      chk({req, " no req"}, mem_req, 0);
      @(negedge clk);
      chk("R10 done single pulse", done, 0);
   endtask

   task automatic run_ind(input string req, input logic [31:0] ins, input logic [19:0] pc,
                          input logic [23:0] x, input logic [19:0] exp_ta, input logic [23:0] rd,
                          input int waits, input logic stray);
      instr = ins; pc_val = pc; idx_val = x; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " req up R8"}, mem_req, 1);
      chk({req, " req addr R8"}, mem_addr, exp_ta);
      chk({req, " no early done"}, done, 0);
      chk("R11 busy", busy, 1);
      for (int k = 0; k < waits; k++) begin
         if (stray && k == 0) begin
            instr = mk3(6'b110000, 12'h123);
            start = 1'b1;
         end
         @(negedge clk);
         start = 1'b0;
         chk({req, " req held R8"}, mem_req, 1);
         chk({req, " addr held R8"}, mem_addr, exp_ta);
         chk("R11 no done while pending", done, 0);
      end
      mem_ack = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = 24'h0;
      chk({req, " req drops R8"}, mem_req, 0);
      chk({req, " done not yet R8"}, done, 0);
      @(negedge clk);
      chk({req, " done R8"}, done, 1);
      chk({req, " ea R8"}, ea, {12'h0, rd[19:0]} & 32'hFFFFF);
      chk({req, " imm R8"}, imm, 0);
      chk({req, " err R8"}, err, 0);
      @(negedge clk);
      chk("R11 no extra done", done, 0);
      chk("R11 idle again", busy, 0);
   endtask

   task automatic t_reset();
      chk("R12 done", done, 0);
      chk("R12 err", err, 0);
      chk("R12 busy", busy, 0);
      chk("R12 req", mem_req, 0);
      chk("R12 ea", ea, 0);
   endtask

   task automatic t_base();
      run_one("R2 base", mk3(6'b110100, 12'h0FF), 24'h0FFF00, 0, 0, 20'hFFFFF, 0, 0, 3);
      run_one("R2 base unsigned disp", mk3(6'b110100, 12'hFFF), 24'h001000, 0, 0, 20'h01FFF, 0, 0, 3);
      run_one("R2 base wrap", mk3(6'b110100, 12'h020), 24'h7FFFF0, 0, 0, 20'h00010, 0, 0, 3);
   endtask

   task automatic t_pcrel();
      run_one("R3 pc neg", mk3(6'b110010, 12'hFFE), 0, 0, 20'h01000, 20'h00FFE, 0, 0, 3);
      run_one("R3 pc min wrap", mk3(6'b110010, 12'h800), 0, 0, 20'h00003, 20'hFF803, 0, 0, 3);
      run_one("R3 pc max", mk3(6'b110010, 12'h7FF), 0, 0, 20'h10000, 20'h107FF, 0, 0, 3);
   endtask

   task automatic t_direct();
      run_one("R4 direct short", mk3(6'b110000, 12'hABC), 24'h055555, 0, 20'h12345, 20'h00ABC, 0, 0, 3);
      run_one("R4 direct long R1", mk4(6'b110001, 20'hC1234), 0, 0, 0, 20'hC1234, 0, 0, 4);
      run_one("R5 index long", mk4(6'b111001, 20'hC1234), 0, 24'h000010, 0, 20'hC1244, 0, 0, 4);
      run_one("R5 index wrap", mk4(6'b111001, 20'hFFFFF), 0, 24'hF00002, 0, 20'h00001, 0, 0, 4);
      run_one("R5 index base", mk3(6'b111100, 12'h010), 24'h000100, 24'h000005, 0, 20'h00115, 0, 0, 3);
   endtask

   task automatic t_imm();
      run_one("R6 imm short", mk3(6'b010000, 12'h01E), 0, 0, 0, 20'h0001E, 1, 0, 3);
      run_one("R6 imm long R1", mk4(6'b010001, 20'h12345), 0, 0, 0, 20'h12345, 1, 0, 4);
   endtask

   task automatic t_legacy();
      run_one("R7 legacy", mk3(6'b000100, 12'h234), 0, 0, 0, 20'h04234, 0, 0, 3);
      run_one("R7 legacy idx", mk3(6'b001100, 12'h234), 0, 24'h000010, 0, 20'h04244, 0, 0, 3);
      run_one("R7 legacy bp set", mk3(6'b000110, 12'h001), 0, 0, 0, 20'h06001, 0, 0, 3);
   endtask

   task automatic t_errors();
      run_one("R9 b and p", mk3(6'b110110, 12'h100), 24'h000100, 0, 20'h00100, 20'h0, 0, 1, 0);
      run_one("R9 x with imm", mk3(6'b011000, 12'h100), 0, 24'h1, 0, 20'h0, 0, 1, 0);
      run_one("R9 x with ind", mk3(6'b101000, 12'h100), 0, 24'h1, 0, 20'h0, 0, 1, 0);
      run_one("R9 e in legacy", mk3(6'b000001, 12'h100), 0, 0, 0, 20'h0, 0, 1, 0);
      run_one("R9 e with b", mk4(6'b110101, 20'h00100), 24'h000100, 0, 0, 20'h0, 0, 1, 0);
      run_one("R9 clears after", mk3(6'b110000, 12'h003), 0, 0, 0, 20'h00003, 0, 0, 3);
   endtask

   task automatic t_indirect();
      run_ind("R8 ind pcrel", mk3(6'b100010, 12'h010), 20'h02000, 0, 20'h02010, 24'hAB1234, 2, 0);
      run_ind("R11 ind stray start", mk3(6'b100000, 12'h444), 20'h0, 0, 20'h00444, 24'h0FEDCB, 3, 1);
      run_ind("R8 ind fast ack", mk4(6'b100001, 20'h80000), 20'h0, 0, 20'h80000, 24'h012345, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_base();
      t_pcrel();
      t_direct();
      t_imm();
      t_legacy();
      t_errors();
      t_indirect();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule